// File: doc/BRIEF.md
# Skewed-Slice Pipelined Integer Adder

This block adds two 32-bit unsigned/two's-complement operands in a pipeline of 16-bit slices, clocked by a fast tick clock in which one tick equals half of a core cycle. The lower result half leaves the low slice one tick after the operands are accepted. The upper half leaves the high slice one tick later, because it needs the registered carry out of the low slice. The status flags follow one tick after that.

Each of the three result streams has its own valid strobe and latency, so a consumer that only needs the low half can use it early. A new operand pair may be presented on every tick, gaps are allowed, and there is no stall path. A synchronous active-high reset empties the pipeline.

Top module: `skew_adder`

## Requirements
- R1: `lo_valid` rises exactly 1 tick after an accepted `in_valid`, and `lo_sum` then equals bits 15:0 of `in_a + in_b`.
- R2: `hi_valid` rises exactly 2 ticks after acceptance, and `hi_sum` then equals bits 31:16 of the full 32-bit sum.
- R3: The carry out of the low slice is added into the high slice; for example, 0x0000FFFF + 0x00000001 gives a high half of 0x0001 and a low half of 0x0000.
- R4: `flag_valid` rises exactly 3 ticks after acceptance, and `flag_zero` is 1 only when all 32 sum bits are zero.
- R5: `flag_neg` equals bit 31 of the sum.
- R6: `flag_carry` equals the carry out of bit 31 (the 33rd bit of the unsigned sum).
- R7: `flag_ovf` is 1 exactly when both operands have the same bit 31 and the sum bit 31 differs from it.
- R8: One operation is accepted on every tick that `in_valid` is 1. Results of back-to-back operations never mix across stages, and a tick with `in_valid` at 0 produces no valid result on any stream.
- R9: While `rst` is high at a clock edge, all three valid outputs are cleared on that edge, including those of operations already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock (one tick is half a core cycle) |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present this tick |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| lo_valid | output | 1 | `lo_sum` holds a result |
| lo_sum | output | 16 | Lower half of the sum |
| hi_valid | output | 1 | `hi_sum` holds a result |
| hi_sum | output | 16 | Upper half of the sum |
| flag_valid | output | 1 | Flag outputs hold a result |
| flag_zero | output | 1 | Sum is zero |
| flag_neg | output | 1 | Sum bit 31 |
| flag_carry | output | 1 | Carry out of bit 31 |
| flag_ovf | output | 1 | Signed overflow |

## Verification
On every cycle, the assertions check the valid chain (each stream valid only one tick after the previous stage was valid), the reset flush, and the agreement between flags and the halves they were formed from: negative against the previous upper half, and zero against both earlier halves. The arithmetic values themselves, the carry crossing between slices, the overflow rule and the rule that neighbouring operations do not mix can only be shown by the bench scenarios. These compare each stream with a reference sum at its own latency, using random traffic with gaps, carry and overflow corner cases, and a reset that arrives while the pipeline is full.

// File: rtl/skew_adder_pkg.sv
package skew_adder_pkg;

    localparam int HALF_W = 16;
    localparam int DATA_W = 2 * HALF_W;

    // Registered state leaving the low slice
    typedef struct packed {
        logic [HALF_W-1:0] sum;
        logic              carry;
        logic [HALF_W-1:0] a_up;
        logic [HALF_W-1:0] b_up;
    } lo_stage_t;

    // Registered state leaving the high slice
    typedef struct packed {
        logic [HALF_W-1:0] sum;
        logic              carry;
        logic              lo_zero;
        logic              a_sign;
        logic              b_sign;
    } hi_stage_t;

    typedef struct packed {
        logic zero;
        logic neg;
        logic carry;
        logic ovf;
    } flags_t;

    // Slice add with carry-in; bit HALF_W of the result is the carry-out
    function automatic logic [HALF_W:0] slice_add(
        input logic [HALF_W-1:0] x,
        input logic [HALF_W-1:0] y,
        input logic              ci
    );
        return {1'b0, x} + {1'b0, y} + {{HALF_W{1'b0}}, ci};
    endfunction

    function automatic logic signed_ovf(
        input logic sa,
        input logic sb,
        input logic sr
    );
        return (sa == sb) && (sr != sa);
    endfunction

endpackage

// File: rtl/skew_lo_slice.sv
module skew_lo_slice
    import skew_adder_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [DATA_W-1:0]    in_a,
    input  logic [DATA_W-1:0]    in_b,
    output logic                 out_valid,
    output lo_stage_t            out_stage
);
    logic [HALF_W:0] lo_res;

    always_comb begin
        lo_res = slice_add(in_a[HALF_W-1:0], in_b[HALF_W-1:0], 1'b0);
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= in_valid;
    end

    // Data registers are qualified by the valid bit and need no reset
    always_ff @(posedge clk) begin
        out_stage.sum   <= lo_res[HALF_W-1:0];
        out_stage.carry <= lo_res[HALF_W];
        out_stage.a_up  <= in_a[DATA_W-1:HALF_W];
        out_stage.b_up  <= in_b[DATA_W-1:HALF_W];
    end
endmodule

// File: rtl/skew_hi_slice.sv
module skew_hi_slice
    import skew_adder_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  lo_stage_t in_stage,
    output logic      out_valid,
    output hi_stage_t out_stage
);
    logic [HALF_W:0] hi_res;

    always_comb begin
        hi_res = slice_add(in_stage.a_up, in_stage.b_up, in_stage.carry);
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= in_valid;
    end

    always_ff @(posedge clk) begin
        out_stage.sum     <= hi_res[HALF_W-1:0];
        out_stage.carry   <= hi_res[HALF_W];
        out_stage.lo_zero <= (in_stage.sum == '0);
        out_stage.a_sign  <= in_stage.a_up[HALF_W-1];
        out_stage.b_sign  <= in_stage.b_up[HALF_W-1];
    end
endmodule

// File: rtl/skew_flag_stage.sv
module skew_flag_stage
    import skew_adder_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  hi_stage_t in_stage,
    output logic      out_valid,
    output flags_t    out_flags
);
    flags_t next_flags;

    always_comb begin
        next_flags.zero  = in_stage.lo_zero && (in_stage.sum == '0);
        next_flags.neg   = in_stage.sum[HALF_W-1];
        next_flags.carry = in_stage.carry;
        next_flags.ovf   = signed_ovf(in_stage.a_sign, in_stage.b_sign,
                                      in_stage.sum[HALF_W-1]);
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= in_valid;
    end

    always_ff @(posedge clk) begin
        out_flags <= next_flags;
    end
endmodule

// File: rtl/skew_adder.sv
module skew_adder
    import skew_adder_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              lo_valid,
    output logic [HALF_W-1:0] lo_sum,
    output logic              hi_valid,
    output logic [HALF_W-1:0] hi_sum,
    output logic              flag_valid,
    output logic              flag_zero,
    output logic              flag_neg,
    output logic              flag_carry,
    output logic              flag_ovf
);
    lo_stage_t lo_q;
    hi_stage_t hi_q;
    flags_t    fl_q;

    skew_lo_slice u_lo (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (lo_valid),
        .out_stage (lo_q)
    );

    skew_hi_slice u_hi (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (lo_valid),
        .in_stage  (lo_q),
        .out_valid (hi_valid),
        .out_stage (hi_q)
    );

    skew_flag_stage u_fl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (hi_valid),
        .in_stage  (hi_q),
        .out_valid (flag_valid),
        .out_flags (fl_q)
    );

    assign lo_sum     = lo_q.sum;
    assign hi_sum     = hi_q.sum;
    assign flag_zero  = fl_q.zero;
    assign flag_neg   = fl_q.neg;
    assign flag_carry = fl_q.carry;
    assign flag_ovf   = fl_q.ovf;
endmodule

// File: rtl/skew_adder_checker.sv
module skew_adder_checker
    import skew_adder_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              lo_valid,
    input logic [HALF_W-1:0] lo_sum,
    input logic              hi_valid,
    input logic [HALF_W-1:0] hi_sum,
    input logic              flag_valid,
    input logic              flag_zero,
    input logic              flag_neg
);
    // R1: low stream valid only one tick after an accepted input
    assert_lo_latency_R1: assert property (@(posedge clk) disable iff (rst)
        lo_valid |-> $past(in_valid));

    // R2: high stream valid only one tick after the low stream
    assert_hi_latency_R2: assert property (@(posedge clk) disable iff (rst)
        hi_valid |-> $past(lo_valid));

    // R4: flag stream valid only one tick after the high stream
    assert_flag_latency_R4: assert property (@(posedge clk) disable iff (rst)
        flag_valid |-> $past(hi_valid));

    // R4: zero flag implies both earlier halves were zero
    assert_zero_halves_R4: assert property (@(posedge clk) disable iff (rst)
        (flag_valid && flag_zero) |-> ($past(hi_sum) == '0 && $past(lo_sum, 2) == '0));

    // R5: negative flag matches the top bit of the preceding upper half
    assert_neg_bit_R5: assert property (@(posedge clk) disable iff (rst)
        flag_valid |-> (flag_neg == $past(hi_sum[HALF_W-1])));

    // R9: a reset edge leaves every stream empty
    assert_reset_flush_R9: assert property (@(posedge clk)
        rst |=> !(lo_valid || hi_valid || flag_valid));
endmodule

bind skew_adder skew_adder_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .lo_valid   (lo_valid),
    .lo_sum     (lo_sum),
    .hi_valid   (hi_valid),
    .hi_sum     (hi_sum),
    .flag_valid (flag_valid),
    .flag_zero  (flag_zero),
    .flag_neg   (flag_neg)
);

// File: tb/tb_skew_adder.sv
`timescale 1ns/1ps
module tb_skew_adder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        lo_valid, hi_valid, flag_valid;
    logic [15:0] lo_sum, hi_sum;
    logic        flag_zero, flag_neg, flag_carry, flag_ovf;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // history of driven ticks: index 0 = most recently captured
    bit          hv [3];
    logic [31:0] ha [3];
    logic [31:0] hb [3];

    always #10 clk = ~clk;

    skew_adder dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .lo_valid(lo_valid), .lo_sum(lo_sum), .hi_valid(hi_valid), .hi_sum(hi_sum),
        .flag_valid(flag_valid), .flag_zero(flag_zero), .flag_neg(flag_neg),
        .flag_carry(flag_carry), .flag_ovf(flag_ovf)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Compare every stream with the model, then drive the next tick
    task automatic tick(input bit r, input bit v, input logic [31:0] a, input logic [31:0] b);
        logic [32:0] s;
        @(negedge clk);
        check("R1", "lo_valid", {31'b0, lo_valid}, {31'b0, hv[0]});
        if (hv[0]) begin
            s = {1'b0, ha[0]} + {1'b0, hb[0]};
            check("R1", "lo_sum", {16'b0, lo_sum}, {16'b0, s[15:0]});
        end
        check("R2", "hi_valid", {31'b0, hi_valid}, {31'b0, hv[1]});
        if (hv[1]) begin
            s = {1'b0, ha[1]} + {1'b0, hb[1]};
            check("R2", "hi_sum", {16'b0, hi_sum}, {16'b0, s[31:16]});
        end
        check("R4", "flag_valid", {31'b0, flag_valid}, {31'b0, hv[2]});
        if (hv[2]) begin
            s = {1'b0, ha[2]} + {1'b0, hb[2]};
            check("R4", "flag_zero", {31'b0, flag_zero}, {31'b0, s[31:0] == 32'd0});
            check("R5", "flag_neg", {31'b0, flag_neg}, {31'b0, s[31]});
            check("R6", "flag_carry", {31'b0, flag_carry}, {31'b0, s[32]});
            check("R7", "flag_ovf", {31'b0, flag_ovf},
                  {31'b0, (ha[2][31] == hb[2][31]) && (s[31] != ha[2][31])});
        end
        rst = r; in_valid = v; in_a = a; in_b = b;
        if (r) begin
            for (int i = 0; i < 3; i++) hv[i] = 1'b0;   // R9 flush expected
        end else begin
            hv[2] = hv[1]; ha[2] = ha[1]; hb[2] = hb[1];
            hv[1] = hv[0]; ha[1] = ha[0]; hb[1] = hb[0];
            hv[0] = v;     ha[0] = a;     hb[0] = b;
        end
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin hv[i] = 1'b0; ha[i] = '0; hb[i] = '0; end
        // reset state
        for (int i = 0; i < 4; i++) tick(1'b1, 1'b0, '0, '0);
        // R3: carry crosses slice boundary
        tick(0, 1, 32'h0000FFFF, 32'h00000001);
        // R4/R6: wrap to zero with carry
        tick(0, 1, 32'hFFFFFFFF, 32'h00000001);
        // R7: positive overflow
        tick(0, 1, 32'h7FFFFFFF, 32'h00000001);
        // R7/R6/R4: negative overflow to zero
        tick(0, 1, 32'h80000000, 32'h80000000);
        // R4: true zero
        tick(0, 1, 32'h00000000, 32'h00000000);
        // R5: negative without overflow
        tick(0, 1, 32'hFFFFFFFE, 32'h00000001);
        // R8: bubble between operations
        tick(0, 0, 32'h12345678, 32'h9ABCDEF0);
        tick(0, 1, 32'h8000FFFF, 32'h7FFF0001);
        for (int i = 0; i < 4; i++) tick(0, 0, '0, '0);
        // R8: random back-to-back traffic with gaps
        for (int i = 0; i < 400; i++)
            tick(0, ($urandom % 4) != 0, $urandom, $urandom);
        // R9: reset while the pipeline is full
        tick(0, 1, 32'h11111111, 32'h22222222);
        tick(0, 1, 32'h33333333, 32'h44444444);
        tick(1, 0, '0, '0);
        tick(0, 0, '0, '0);
        tick(0, 0, '0, '0);
        for (int i = 0; i < 200; i++)
            tick(0, 1'b1, $urandom, $urandom);
        for (int i = 0; i < 4; i++) tick(0, 0, '0, '0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule